// File: doc/BRIEF.md
# Dual-Channel High/Low Count Pulse Generator

This block produces two independent pulse-width-modulated outputs. Each output is set by two counts instead of a period and a compare value. The first count gives the length of the high phase and the second gives the length of the low phase. Every period begins with its high phase. There is no inversion control, so the only way to change the sense of the waveform is to swap the two counts.

Each channel advances on its own count tick. The tick comes from a prescaler with three stages: it selects one of four source strobes, divides that strobe by a programmable ratio, and passes the result through an enable gate. The source strobes are single-cycle clock-enable pulses in the system clock domain, so the block never multiplexes a real clock.

Software reaches the block through a 32-bit register interface with three registers: one count word per channel and one control word that both channels share. Each channel has a small state machine. Its states are PH_OFF, PH_HIGH and PH_LOW, and its transitions are the following:

- **start**: PH_OFF to PH_HIGH, or to PH_LOW when the high count is zero, once the channel is enabled.
- **high_done**: PH_HIGH to PH_LOW.
- **period_end**: PH_LOW back to PH_HIGH or PH_LOW, reloading the counts.
- **halt**: any state to PH_OFF when the enable bit is cleared.

Top module: `dual_hilo_pwm`

## Requirements
- R1: The register map is as follows. Channel A's count word is at byte offset 0x0, channel B's count word is at 0x4, and the shared control word is at 0x8. A read at any of these offsets returns the last value written there. A read at any other offset returns zero.
- R2: In a count word, bits 31:16 hold the high count `hi` and bits 15:0 hold the low count `lo`. An enabled channel repeats the pattern of `hi` ticks high followed by `lo` ticks low, and each period starts high.
- R3: When `lo` is zero, the low phase lasts exactly one tick per period. This also holds at `hi` = 0xFFFF.
- R4: When `hi` is zero, the output stays low for the whole time.
- R5: Control bit 0 enables channel A and control bit 1 enables channel B. Writing a zero to a channel's enable bit drives that output low from the cycle that follows the write. The output does not wait for the period to end.
- R6: The divider field sits at control bits 14:8 for channel A and bits 22:16 for channel B. A divider value of N produces one tick for every N+1 strobes of the selected source.
- R7: The source select field sits at control bits 5:4 for channel A and bits 7:6 for channel B. Its value k picks src_tick[k] as the strobe for that channel.
- R8: The gate bit is control bit 15 for channel A and bit 23 for channel B. While the gate bit is clear, the channel's counters stand still and its output holds its level. Setting the bit again resumes the pattern.
- R9: Counts written while a channel is running do not change the period in progress. They take effect at the next period boundary.
- R10: After reset, both outputs are low and every register reads zero.
- R11: Each channel's output depends only on that channel's own fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| src_tick | input | 4 | Four clock-enable source strobes |
| pwm_out | output | 2 | Bit 0 is channel A's output and bit 1 is channel B's output |

## Verification
The bench builds the block with its default widths: 16-bit counts, a 7-bit divider and four sources. These widths let the bench run one full period at the largest high count (0xFFFF with a zero low count) and still stay within the run budget. It feeds the sources as a constant strobe, a one-in-three strobe, a one-in-four strobe and an idle strobe. With these, every source index and several divider ratios produce run lengths that the bench can predict exactly in system cycles. It also writes new counts in the middle of a high phase and stops the gate in the middle of a phase. These two cases reach the reload at the period boundary and the frozen state.

// File: rtl/hilo_pwm_pkg.sv
package hilo_pwm_pkg;

    localparam int REG_W   = 32;
    localparam int ADDR_W  = 4;
    localparam int CNT_W   = 16;
    localparam int DIV_W   = 7;
    localparam int NUM_SRC = 4;
    localparam int SEL_W   = $clog2(NUM_SRC);
    localparam int NUM_CH  = 2;

    localparam logic [ADDR_W-1:0] OFS_CNT_A = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_CNT_B = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 4'h8;

    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

    // Control word field positions for a given channel.
    function automatic int en_bit(input int ch);
        return ch;
    endfunction

    function automatic int sel_lsb(input int ch);
        return 4 + SEL_W * ch;
    endfunction

    function automatic int div_lsb(input int ch);
        return 8 + 8 * ch;
    endfunction

    function automatic int gate_bit(input int ch);
        return 15 + 8 * ch;
    endfunction

endpackage

// File: rtl/hilo_pwm_regs.sv
module hilo_pwm_regs
    import hilo_pwm_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [REG_W-1:0]              wdata,
    output logic [REG_W-1:0]              rdata,
    output logic [NUM_CH-1:0][REG_W-1:0]  cnt_words,
    output logic [REG_W-1:0]              ctrl_word
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_words <= '0;
            ctrl_word <= '0;
        end else if (we) begin
            case (addr)
                OFS_CNT_A: cnt_words[0] <= wdata;
                OFS_CNT_B: cnt_words[1] <= wdata;
                OFS_CTRL:  ctrl_word    <= wdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            OFS_CNT_A: rdata = cnt_words[0];
            OFS_CNT_B: rdata = cnt_words[1];
            OFS_CTRL:  rdata = ctrl_word;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/hilo_pwm_prescaler.sv
module hilo_pwm_prescaler #(
    parameter int NSRC   = 4,
    parameter int DIVW   = 7,
    localparam int SELW  = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_tick,
    input  logic [SELW-1:0] sel,
    input  logic [DIVW-1:0] div,
    input  logic            gate,
    output logic            tick
);

    logic [DIVW-1:0] div_cnt;
    logic            src_hit;
    logic            wrap;

    assign src_hit = src_tick[sel];
    assign wrap    = (div_cnt >= div);
    assign tick    = gate & src_hit & wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (gate && src_hit) begin
            div_cnt <= wrap ? '0 : div_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/hilo_pwm_phase_fsm.sv
module hilo_pwm_phase_fsm
    import hilo_pwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic [CW-1:0] hi_cnt,
    input  logic [CW-1:0] lo_cnt,
    output logic          pwm,
    output logic          running
);

    phase_e        state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] hi_sh_q, hi_sh_d;
    logic [CW-1:0] lo_sh_q, lo_sh_d;
    logic [CW-1:0] lo_last;
    logic          load;

    // A zero low count still spends one tick low.
    assign lo_last = (lo_sh_q == '0) ? '0 : lo_sh_q - 1'b1;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        hi_sh_d = hi_sh_q;
        lo_sh_d = lo_sh_q;
        load    = 1'b0;
        unique case (state_q)
            PH_OFF: begin
                if (en) load = 1'b1;                      // start
            end
            PH_HIGH: begin
                if (tick) begin
                    if (cnt_q == hi_sh_q - 1'b1) begin    // high_done
                        state_d = PH_LOW;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            PH_LOW: begin
                if (tick) begin
                    if (cnt_q >= lo_last) load = 1'b1;    // period_end
                    else                  cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = PH_OFF;
        endcase
        if (load) begin
            hi_sh_d = hi_cnt;
            lo_sh_d = lo_cnt;
            cnt_d   = '0;
            state_d = (hi_cnt != '0) ? PH_HIGH : PH_LOW;
        end
        if (!en) begin                                    // halt
            state_d = PH_OFF;
            cnt_d   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_OFF;
            cnt_q   <= '0;
            hi_sh_q <= '0;
            lo_sh_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            hi_sh_q <= hi_sh_d;
            lo_sh_q <= lo_sh_d;
        end
    end

    always_comb begin
        pwm     = en && (state_q == PH_HIGH);
        running = (state_q != PH_OFF);
    end

endmodule

// File: rtl/dual_hilo_pwm.sv
module dual_hilo_pwm
    import hilo_pwm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic [NUM_SRC-1:0] src_tick,
    output logic [NUM_CH-1:0]  pwm_out
);

    logic [NUM_CH-1:0][REG_W-1:0] cnt_words;
    logic [REG_W-1:0]             ctrl_q;
    logic [NUM_CH-1:0]            cnt_tick;
    logic [NUM_CH-1:0]            ch_run;
    logic                         unused_ctrl_bits;

    assign unused_ctrl_bits = ^{ctrl_q[3:2], ctrl_q[31:24]};

    hilo_pwm_regs i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .cnt_words (cnt_words),
        .ctrl_word (ctrl_q)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam int EN_B   = en_bit(ch);
        localparam int SEL_L  = sel_lsb(ch);
        localparam int DIV_L  = div_lsb(ch);
        localparam int GATE_B = gate_bit(ch);

        hilo_pwm_prescaler #(
            .NSRC (NUM_SRC),
            .DIVW (DIV_W)
        ) i_presc (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_tick (src_tick),
            .sel      (ctrl_q[SEL_L +: SEL_W]),
            .div      (ctrl_q[DIV_L +: DIV_W]),
            .gate     (ctrl_q[GATE_B]),
            .tick     (cnt_tick[ch])
        );

        hilo_pwm_phase_fsm #(
            .CW (CNT_W)
        ) i_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (ctrl_q[EN_B]),
            .tick    (cnt_tick[ch]),
            .hi_cnt  (cnt_words[ch][CNT_W +: CNT_W]),
            .lo_cnt  (cnt_words[ch][0 +: CNT_W]),
            .pwm     (pwm_out[ch]),
            .running (ch_run[ch])
        );
    end

endmodule

// File: rtl/hilo_pwm_checker.sv
module hilo_pwm_checker
    import hilo_pwm_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               reg_we,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [REG_W-1:0]   reg_wdata,
    input logic [REG_W-1:0]   reg_rdata,
    input logic [NUM_CH-1:0]  pwm_out,
    input logic [NUM_CH-1:0]  tick,
    input logic [NUM_CH-1:0]  run,
    input logic [REG_W-1:0]   ctrl
);

    p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != OFS_CNT_A && reg_addr != OFS_CNT_B && reg_addr != OFS_CTRL)
        |-> (reg_rdata == '0));

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
        localparam int EN_B  = en_bit(ch);
        localparam int DIV_L = div_lsb(ch);

        p_disable_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_addr == OFS_CTRL && !reg_wdata[EN_B]) |=> !pwm_out[ch]);

        p_freeze_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl[EN_B] && $past(ctrl[EN_B]) && $past(run[ch]) && !$past(tick[ch]))
            |-> $stable(pwm_out[ch]));

        p_tick_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (tick[ch] && ctrl[DIV_L +: DIV_W] != '0)
            |=> (!tick[ch] || ctrl[DIV_L +: DIV_W] == '0));
    end

endmodule

bind dual_hilo_pwm hilo_pwm_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pwm_out   (pwm_out),
    .tick      (cnt_tick),
    .run       (ch_run),
    .ctrl      (ctrl_q)
);

// File: tb/test_dual_hilo_pwm.sv
module test_dual_hilo_pwm;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  src_tick = 4'b0001;
    logic [1:0]  pwm_out;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    localparam int LIM = 70000;

    always #2 clk = ~clk;

    dual_hilo_pwm i_dual_hilo_pwm (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .src_tick  (src_tick),
        .pwm_out   (pwm_out)
    );

    // Source strobes: constant, one in three, one in four, idle.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        src_tick <= {1'b0, ((cyc + 1) % 4) == 0, ((cyc + 1) % 3) == 0, 1'b1};
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ctl(input int ch, input int sel, input int dv,
                                        input bit gate, input bit en);
        logic [31:0] v = '0;
        v[ch] = en;
        v[4 + 2*ch +: 2] = sel[1:0];
        v[8 + 8*ch +: 7] = dv[6:0];
        v[15 + 8*ch] = gate;
        return v;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
    endtask

    task automatic measure(input int ch, input bit from_start, output int hi_len, output int lo_len);
        int g;
        if (!from_start) begin
            g = 0; while (!pwm_out[ch] && g < LIM) begin @(negedge clk); g++; end
            g = 0; while (pwm_out[ch] && g < LIM) begin @(negedge clk); g++; end
        end
        g = 0; while (!pwm_out[ch] && g < LIM) begin @(negedge clk); g++; end
        hi_len = 0; while (pwm_out[ch] && hi_len < LIM) begin hi_len++; @(negedge clk); end
        lo_len = 0; while (!pwm_out[ch] && lo_len < LIM) begin lo_len++; @(negedge clk); end
    endtask

    task automatic run_a(input int hi, input int lo, input int sel, input int dv,
                         input bit from_start, input int exp_hi, input int exp_lo, input string tag);
        int h, l;
        wr(4'h8, 32'h0);
        wr(4'h0, {hi[15:0], lo[15:0]});
        wr(4'h8, ctl(0, sel, dv, 1'b1, 1'b1));
        measure(0, from_start, h, l);
        chk({tag, " high run"}, h, exp_hi);
        chk({tag, " low run"}, l, exp_lo);
    endtask

    task automatic t_reset_r10();
        logic [31:0] d;
        chk("R10 outputs after reset", {30'd0, pwm_out}, 32'd0);
        rd(4'h0, d); chk("R10 count A after reset", d, 32'd0);
        rd(4'h4, d); chk("R10 count B after reset", d, 32'd0);
        rd(4'h8, d); chk("R10 control after reset", d, 32'd0);
    endtask

    task automatic t_regmap_r1();
        logic [31:0] d;
        wr(4'h0, 32'hA5A5_1234);
        wr(4'h4, 32'h5A5A_8765);
        wr(4'h8, 32'h00FF_FFFC);
        rd(4'h0, d); chk("R1 readback count A", d, 32'hA5A5_1234);
        rd(4'h4, d); chk("R1 readback count B", d, 32'h5A5A_8765);
        rd(4'h8, d); chk("R1 readback control", d, 32'h00FF_FFFC);
        rd(4'hC, d); chk("R1 unmapped offset", d, 32'd0);
        chk("R1 outputs idle with enables clear", {30'd0, pwm_out}, 32'd0);
        wr(4'h8, 32'h0);
    endtask

    task automatic t_shape_r2();
        run_a(3, 2, 0, 0, 1'b1, 3, 2, "R2 hi=3 lo=2");
        run_a(1, 4, 0, 0, 1'b1, 1, 4, "R2 hi=1 lo=4");
    endtask

    task automatic t_lo_zero_r3();
        run_a(5, 0, 0, 0, 1'b1, 5, 1, "R3 hi=5 lo=0");
        run_a(16'hFFFF, 0, 0, 0, 1'b1, 65535, 1, "R3 hi=max lo=0");
    endtask

    task automatic t_hi_zero_r4();
        int highs = 0;
        wr(4'h8, 32'h0);
        wr(4'h0, {16'd0, 16'd5});
        wr(4'h8, ctl(0, 0, 0, 1'b1, 1'b1));
        for (int i = 0; i < 40; i++) begin highs += pwm_out[0]; @(negedge clk); end
        chk("R4 hi=0 lo=5 high samples", highs, 0);
        wr(4'h0, 32'd0);
        highs = 0;
        for (int i = 0; i < 40; i++) begin highs += pwm_out[0]; @(negedge clk); end
        chk("R4 hi=0 lo=0 high samples", highs, 0);
    endtask

    task automatic t_disable_r5();
        int g = 0;
        wr(4'h8, 32'h0);
        wr(4'h0, {16'd50, 16'd50});
        wr(4'h8, ctl(0, 0, 0, 1'b1, 1'b1));
        while (!pwm_out[0] && g < 200) begin @(negedge clk); g++; end
        repeat (3) @(negedge clk);
        chk("R5 output high before disable", pwm_out[0], 1'b1);
        wr(4'h8, ctl(0, 0, 0, 1'b1, 1'b0));
        chk("R5 output low right after disable", pwm_out[0], 1'b0);
    endtask

    task automatic t_divider_r6();
        run_a(2, 3, 0, 2, 1'b0, 6, 9, "R6 div=2");
        run_a(1, 1, 1, 1, 1'b0, 6, 6, "R6 div=1 on 1-in-3 source");
    endtask

    task automatic t_select_r7();
        run_a(2, 1, 2, 0, 1'b0, 8, 4, "R7 sel=2");
        run_a(2, 1, 1, 0, 1'b0, 6, 3, "R7 sel=1");
    endtask

    task automatic t_gate_r8();
        logic v; int changes = 0; int h, l;
        run_a(3, 3, 0, 0, 1'b1, 3, 3, "R8 before gate");
        @(negedge clk);
        wr(4'h8, ctl(0, 0, 0, 1'b0, 1'b1));
        v = pwm_out[0];
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (pwm_out[0] !== v) changes++; end
        chk("R8 output changes while gated", changes, 0);
        wr(4'h8, ctl(0, 0, 0, 1'b1, 1'b1));
        measure(0, 1'b0, h, l);
        chk("R8 high run after regate", h, 3);
        chk("R8 low run after regate", l, 3);
    endtask

    task automatic t_boundary_r9();
        int g = 0; int h, l;
        wr(4'h8, 32'h0);
        wr(4'h0, {16'd4, 16'd4});
        wr(4'h8, ctl(0, 0, 0, 1'b1, 1'b1));
        while (!pwm_out[0] && g < 100) begin @(negedge clk); g++; end
        h = 1;
        wr(4'h0, {16'd7, 16'd2});
        while (pwm_out[0] && h < 100) begin h++; @(negedge clk); end
        l = 0;
        while (!pwm_out[0] && l < 100) begin l++; @(negedge clk); end
        chk("R9 current high keeps old count", h, 4);
        chk("R9 current low keeps old count", l, 4);
        measure(0, 1'b0, h, l);
        chk("R9 next high uses new count", h, 7);
        chk("R9 next low uses new count", l, 2);
    endtask

    task automatic t_indep_r11();
        int highs = 0; int h, l;
        wr(4'h8, 32'h0);
        wr(4'h0, {16'd3, 16'd3});
        wr(4'h4, {16'd2, 16'd2});
        wr(4'h8, ctl(1, 0, 0, 1'b1, 1'b1) | ctl(0, 0, 0, 1'b1, 1'b0));
        for (int i = 0; i < 40; i++) begin highs += pwm_out[0]; @(negedge clk); end
        chk("R11 channel A idle while B runs", highs, 0);
        measure(1, 1'b0, h, l);
        chk("R11 channel B high run", h, 2);
        chk("R11 channel B low run", l, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r10();
        t_regmap_r1();
        t_shape_r2();
        t_lo_zero_r3();
        t_hi_zero_r4();
        t_disable_r5();
        t_divider_r6();
        t_select_r7();
        t_gate_r8();
        t_boundary_r9();
        t_indep_r11();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule